// File: doc/BRIEF.md
# Single-Wire Bus Slave Time-Slot Engine

This block is the bit-level slave side of a single-wire, open-drain bus. The raw line enters through a flop synchronizer and an edge detector. The engine measures every low pulse in microsecond ticks. The tick comes from a parameterised divider of the system clock that restarts on each falling edge. From those measurements it recognises bus resets and answers each one with a presence pulse. It decodes write slots into received bits. In read slots it pulls the line low to send a 0. It never pulls for a 1.

Two timing sets exist, one for regular speed and one for overdrive speed. An upper layer enters overdrive by strobing a request. The engine leaves overdrive only on a long reset. A short reset given in overdrive keeps the fast speed. The upper layers see three one-cycle strobes: reset seen, bit received (with its value) and bit needed. Before each slot starts they set the transmit enable and the transmit bit, which say whether the next slot is a read slot and what to send in it.

Top module: `owse_engine`

## Requirements
- R1: While `rst` is high and on the cycle after it, `pull_dn` is 0, `od_active` is 0 (regular speed) and no strobe is raised.
- R2: At regular speed, a low pulse of 480 µs or more is a reset. One `rst_stb` pulse appears only after the line has risen again. A low pulse of 479 µs raises no reset strobe.
- R3: After a reset, the engine waits 30 µs (3 µs in overdrive) from the rising edge. It then holds `pull_dn` high for 120 µs (12 µs in overdrive) as the presence pulse. The timing set used is the speed that holds after that reset.
- R4: In a write slot, the line level is sampled 30 µs after the falling edge (3 µs in overdrive). A low level gives bit 0 and a high level gives bit 1. Each slot gives exactly one `rx_stb` with the bit on `rx_bit`. The strobe comes at the later of the line rising and the sample point plus 1 µs.
- R5: If `tx_en` is high at the falling edge, the slot is a read slot. With `tx_bit`=0 the engine drives `pull_dn` from the edge until 30 µs after it (3 µs in overdrive). With `tx_bit`=1 it never drives. A read slot raises `need_stb` once and never `rx_stb`.
- R6: A one-cycle `od_req` pulse sets `od_active`. The overdrive timing set then applies from the next slot on.
- R7: In overdrive, a low pulse of 480 µs or more raises `rst_stb`, clears `od_active` and is answered with a presence pulse at regular timing.
- R8: In overdrive, a low pulse of 48 µs to 80 µs raises `rst_stb`, keeps `od_active` set and is answered with an overdrive presence pulse.
- R9: Some low pulses are ignored: those longer than a slot (120 µs regular, 16 µs overdrive) that are not a reset. For overdrive this means 17–47 µs and 81–479 µs; for regular speed, 121–479 µs. They raise no strobe and no presence pulse, and the next slot decodes normally. A 120 µs low at regular speed is still a valid write-0 slot.
- R10: If the master holds the line low into reset length during a slot, the slot is aborted. This also applies to a read-0 slot. Only `rst_stb` is raised, never `rx_stb` or `need_stb`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset (power-on) |
| line_in | input | 1 | Raw bus level, asynchronous |
| tx_en | input | 1 | Next slot is a read slot; sampled at the falling edge |
| tx_bit | input | 1 | Bit to send in a read slot; sampled at the falling edge |
| od_req | input | 1 | One-cycle request to enter overdrive speed |
| pull_dn | output | 1 | Open-drain pull-down enable for the bus |
| rst_stb | output | 1 | One-cycle strobe: bus reset recognised |
| rx_stb | output | 1 | One-cycle strobe: write-slot bit received |
| rx_bit | output | 1 | Value of the last received bit |
| need_stb | output | 1 | One-cycle strobe: read slot finished, next bit wanted |
| od_active | output | 1 | Overdrive speed in force |

## Verification
The assertions assume a few things about the inputs. `tx_en` and `tx_bit` are already stable when the master's falling edge reaches the synchronizer. `od_req` is only pulsed while the bus is idle. Every master low phase and recovery lasts at least one whole microsecond tick, so that one strobe cannot follow another in back-to-back cycles. The stimulus changes the line, `tx_en`, `tx_bit` and `od_req` only on falling clock edges, in whole-tick steps, between slots. It keeps at least 3 µs of high time after every slot before the next falling edge.

// File: rtl/owse_pkg.sv
package owse_pkg;

  localparam int unsigned OWSE_TW = 16;

  typedef logic [OWSE_TW-1:0] owse_us_t;

  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SLOT,
    ST_PWAIT,
    ST_PDRV
  } owse_st_t;

  typedef enum logic [1:0] {
    PK_SLOT,
    PK_RST_LONG,
    PK_RST_SHORT,
    PK_DROP
  } owse_pulse_t;

  typedef struct packed {
    owse_us_t slot_max;
    owse_us_t sample;
    owse_us_t rdhold;
    owse_us_t pwait;
    owse_us_t plen;
  } owse_tset_t;

  // Sort a finished low pulse by its length in microseconds
  function automatic owse_pulse_t owse_classify(
    input owse_us_t len,
    input logic     od,
    input owse_us_t rst_min,
    input owse_us_t od_rst_min,
    input owse_us_t od_keep,
    input owse_us_t slot_max
  );
    if (len >= rst_min)                                   return PK_RST_LONG;
    else if (od && (len >= od_rst_min) && (len <= od_keep)) return PK_RST_SHORT;
    else if (len <= slot_max)                             return PK_SLOT;
    else                                                  return PK_DROP;
  endfunction

endpackage

// File: rtl/owse_sync.sv
module owse_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic raw,
  output logic line_s,
  output logic fall,
  output logic rise
);
  logic [STAGES-1:0] chain;
  logic              last;

  always_ff @(posedge clk) begin
    if (rst) begin
      chain <= '1;
      last  <= 1'b1;
    end else begin
      chain <= {chain[STAGES-2:0], raw};
      last  <= chain[STAGES-1];
    end
  end

  assign line_s = chain[STAGES-1];
  assign fall   = last & ~line_s;
  assign rise   = ~last & line_s;
endmodule

// File: rtl/owse_ustimer.sv
module owse_ustimer #(
  parameter int DIV = 50,
  parameter int TW  = 16
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          restart,
  output logic [TW-1:0] elapsed
);
  localparam int PW      = (DIV > 1) ? $clog2(DIV) : 1;
  localparam int PRE_RST = (DIV > 1) ? 1 : 0;

  logic [PW-1:0] pre;
  logic          tick;

  assign tick = (pre == PW'(DIV - 1));

  // Restarting at 1 aligns tick k with the k-th full microsecond after the edge
  always_ff @(posedge clk) begin
    if (rst || restart) begin
      pre     <= PW'(PRE_RST);
      elapsed <= '0;
    end else if (tick) begin
      pre <= '0;
      if (elapsed != '1) elapsed <= elapsed + 1'b1;
    end else begin
      pre <= pre + 1'b1;
    end
  end
endmodule

// File: rtl/owse_speed.sv
module owse_speed (
  input  logic clk,
  input  logic rst,
  input  logic od_req,
  input  logic rst_long,
  output logic od
);
  always_ff @(posedge clk) begin
    if (rst)           od <= 1'b0;
    else if (rst_long) od <= 1'b0;
    else if (od_req)   od <= 1'b1;
  end
endmodule

// File: rtl/owse_engine.sv
module owse_engine
  import owse_pkg::*;
#(
  parameter int TICK_DIV       = 50,
  parameter int SYNC_STAGES    = 2,
  parameter int RST_US         = 480,
  parameter int OD_RST_US      = 48,
  parameter int OD_KEEP_US     = 80,
  parameter int SLOT_MAX_US    = 120,
  parameter int OD_SLOT_MAX_US = 16,
  parameter int SAMPLE_US      = 30,
  parameter int OD_SAMPLE_US   = 3,
  parameter int RDHOLD_US      = 30,
  parameter int OD_RDHOLD_US   = 3,
  parameter int PWAIT_US       = 30,
  parameter int OD_PWAIT_US    = 3,
  parameter int PLEN_US        = 120,
  parameter int OD_PLEN_US     = 12
) (
  input  logic clk,
  input  logic rst,
  input  logic line_in,
  input  logic tx_en,
  input  logic tx_bit,
  input  logic od_req,
  output logic pull_dn,
  output logic rst_stb,
  output logic rx_stb,
  output logic rx_bit,
  output logic need_stb,
  output logic od_active
);
  localparam owse_us_t RST_MIN    = owse_us_t'(RST_US);
  localparam owse_us_t OD_RST_MIN = owse_us_t'(OD_RST_US);
  localparam owse_us_t OD_KEEP    = owse_us_t'(OD_KEEP_US);

  localparam owse_tset_t REG_SET = '{
    slot_max: owse_us_t'(SLOT_MAX_US),
    sample:   owse_us_t'(SAMPLE_US),
    rdhold:   owse_us_t'(RDHOLD_US),
    pwait:    owse_us_t'(PWAIT_US),
    plen:     owse_us_t'(PLEN_US)
  };
  localparam owse_tset_t OD_SET = '{
    slot_max: owse_us_t'(OD_SLOT_MAX_US),
    sample:   owse_us_t'(OD_SAMPLE_US),
    rdhold:   owse_us_t'(OD_RDHOLD_US),
    pwait:    owse_us_t'(OD_PWAIT_US),
    plen:     owse_us_t'(OD_PLEN_US)
  };

  logic        line_s, fall, rise;
  owse_us_t    el;
  logic        restart;
  logic        od, rst_long;
  owse_tset_t  tset;
  owse_st_t    st;
  logic        pull_q, rst_q, rx_q, bit_q, need_q;
  logic        rd_q, smp_q, rose_q;
  owse_us_t    len_q, len_now;
  logic        slot_end;
  owse_pulse_t kind;

  owse_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk(clk), .rst(rst), .raw(line_in),
    .line_s(line_s), .fall(fall), .rise(rise)
  );

  owse_ustimer #(.DIV(TICK_DIV), .TW(OWSE_TW)) u_timer (
    .clk(clk), .rst(rst), .restart(restart), .elapsed(el)
  );

  owse_speed u_speed (
    .clk(clk), .rst(rst), .od_req(od_req), .rst_long(rst_long), .od(od)
  );

  always_comb begin
    tset     = od ? OD_SET : REG_SET;
    len_now  = rose_q ? len_q : el;
    slot_end = (st == ST_SLOT) && (rise || rose_q) && (el > tset.sample);
    kind     = owse_classify(len_now, od, RST_MIN, OD_RST_MIN, OD_KEEP, tset.slot_max);
    rst_long = slot_end && (kind == PK_RST_LONG);
    restart  = ((st == ST_IDLE) && fall)
            || (slot_end && ((kind == PK_RST_LONG) || (kind == PK_RST_SHORT)))
            || ((st == ST_PWAIT) && (el >= tset.pwait));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      st     <= ST_IDLE;
      pull_q <= 1'b0;
      rst_q  <= 1'b0;
      rx_q   <= 1'b0;
      bit_q  <= 1'b0;
      need_q <= 1'b0;
      rd_q   <= 1'b0;
      smp_q  <= 1'b1;
      rose_q <= 1'b0;
      len_q  <= '0;
    end else begin
      rst_q  <= 1'b0;
      rx_q   <= 1'b0;
      need_q <= 1'b0;
      unique case (st)
        ST_IDLE: begin
          rose_q <= 1'b0;
          if (fall) begin
            st     <= ST_SLOT;
            rd_q   <= tx_en;
            pull_q <= tx_en & ~tx_bit;
          end
        end
        ST_SLOT: begin
          if (pull_q && (el >= tset.rdhold)) pull_q <= 1'b0;
          if (el == tset.sample) smp_q <= line_s;
          if (rise && !rose_q) begin
            rose_q <= 1'b1;
            len_q  <= el;
          end
          if (slot_end) begin
            pull_q <= 1'b0;
            unique case (kind)
              PK_SLOT: begin
                st <= ST_IDLE;
                if (rd_q) need_q <= 1'b1;
                else begin
                  rx_q  <= 1'b1;
                  bit_q <= smp_q;
                end
              end
              PK_RST_LONG, PK_RST_SHORT: begin
                st    <= ST_PWAIT;
                rst_q <= 1'b1;
              end
              default: st <= ST_IDLE;
            endcase
          end
        end
        ST_PWAIT: begin
          if (el >= tset.pwait) begin
            st     <= ST_PDRV;
            pull_q <= 1'b1;
          end
        end
        ST_PDRV: begin
          if (el >= tset.plen) begin
            st     <= ST_IDLE;
            pull_q <= 1'b0;
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  assign pull_dn   = pull_q;
  assign rst_stb   = rst_q;
  assign rx_stb    = rx_q;
  assign rx_bit    = bit_q;
  assign need_stb  = need_q;
  assign od_active = od;
endmodule

// File: rtl/owse_engine_chk.sv
module owse_engine_chk
  import owse_pkg::*;
(
  input logic     clk,
  input logic     rst,
  input logic     pull_dn,
  input logic     rst_stb,
  input logic     rx_stb,
  input logic     need_stb,
  input logic     od_active,
  input logic     od_req,
  input logic     tx_en,
  input logic     tx_bit,
  input logic     line_s,
  input logic     fall,
  input owse_st_t st
);
  AST_RESET_CLEAN: assert property (@(posedge clk)
    rst |=> (!pull_dn && !od_active && !rst_stb && !rx_stb && !need_stb)); // R1

  AST_SINGLE_STROBE: assert property (@(posedge clk) disable iff (rst)
    $onehot0({rst_stb, rx_stb, need_stb})); // R4

  AST_STROBE_LINE_HIGH: assert property (@(posedge clk) disable iff (rst)
    (rst_stb || rx_stb || need_stb) |-> line_s); // R2

  AST_PRES_WAITS: assert property (@(posedge clk) disable iff (rst)
    rst_stb |-> !pull_dn); // R3

  AST_ONE_NO_PULL: assert property (@(posedge clk) disable iff (rst)
    ((st == ST_IDLE) && fall && tx_en && tx_bit) |=> !pull_dn); // R5

  AST_OD_ENTRY: assert property (@(posedge clk) disable iff (rst)
    $rose(od_active) |-> $past(od_req)); // R6

  AST_OD_EXIT: assert property (@(posedge clk) disable iff (rst)
    $fell(od_active) |-> rst_stb); // R7
endmodule

bind owse_engine owse_engine_chk u_chk (
  .clk(clk), .rst(rst), .pull_dn(pull_dn), .rst_stb(rst_stb), .rx_stb(rx_stb),
  .need_stb(need_stb), .od_active(od_active), .od_req(od_req), .tx_en(tx_en),
  .tx_bit(tx_bit), .line_s(line_s), .fall(fall), .st(st)
);

// File: tb/owse_engine_test.sv
module owse_engine_test;
  localparam int DIV = 8;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic mst_rel = 1'b1;
  logic tx_en = 1'b0;
  logic tx_bit = 1'b1;
  logic od_req = 1'b0;
  logic pull_dn, rst_stb, rx_stb, rx_bit, need_stb, od_active;
  logic bus;

  assign bus = mst_rel & ~pull_dn;

  always #10 clk = ~clk;

  owse_engine #(.TICK_DIV(DIV)) uut (
    .clk(clk), .rst(rst), .line_in(bus), .tx_en(tx_en), .tx_bit(tx_bit),
    .od_req(od_req), .pull_dn(pull_dn), .rst_stb(rst_stb), .rx_stb(rx_stb),
    .rx_bit(rx_bit), .need_stb(need_stb), .od_active(od_active)
  );

  int    tests = 0;
  int    fails = 0;
  int    pd_exp = 2;
  string pd_tag = "R1";
  int    n_rst = 0, n_rx = 0, n_need = 0, last_rx = 0;
  bit    od_m = 1'b0;
  bit    done = 1'b0;

  // Per-clock reference: pull_dn compared with the expected level, 2 = guard band
  always begin
    @(posedge clk);
    #5;
    if (!rst) begin
      if (rst_stb) n_rst++;
      if (rx_stb) begin n_rx++; last_rx = int'(rx_bit); end
      if (need_stb) n_need++;
      if (pd_exp != 2) begin
        tests++;
        if (pull_dn !== pd_exp[0]) begin
          fails++;
          $display("FAIL %s pull_dn actual=%0b expected=%0d at %0t", pd_tag, pull_dn, pd_exp, $time);
        end
      end
    end
  end

  task automatic chk(input string req, input int act, input int exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wait_us(input int us);
    repeat (us * DIV) @(negedge clk);
  endtask

  task automatic clr();
    n_rst = 0; n_rx = 0; n_need = 0;
  endtask

  task automatic do_reset(input string req, input int us, input int exp_rst,
                          input bit exp_od, input int guard);
    int pw, pl, first;
    pw = exp_od ? 3 : 30;
    pl = exp_od ? 12 : 120;
    first = (guard > 1) ? guard : 1;
    clr();
    pd_tag = req;
    pd_exp = (guard > 0) ? 2 : 0;
    mst_rel = 1'b0;
    wait_us(1);
    tx_en = 1'b0;
    wait_us(first - 1);
    pd_exp = 0;
    wait_us(us - first);
    mst_rel = 1'b1;
    if (exp_rst != 0) begin
      repeat (pw * DIV) @(negedge clk);
      pd_exp = 2;
      repeat (DIV) @(negedge clk);
      pd_exp = 1;
      repeat ((pl - 1) * DIV) @(negedge clk);
      pd_exp = 2;
      repeat (DIV) @(negedge clk);
      pd_exp = 0;
      wait_us(5);
    end else begin
      wait_us(160);
    end
    chk({req, " reset strobes"}, n_rst, exp_rst);
    chk({req, " no bit strobe"}, n_rx + n_need, 0);
    chk({req, " speed after"}, int'(od_active), int'(exp_od));
    od_m = exp_od;
  endtask

  task automatic write_slot(input string req, input bit b, input int lowus, input int exp_valid);
    int rest;
    rest = (od_m ? 14 : 75) - lowus;
    if (rest < 3) rest = 3;
    clr();
    pd_tag = req;
    pd_exp = 0;
    mst_rel = 1'b0;
    wait_us(lowus);
    mst_rel = 1'b1;
    wait_us(rest);
    chk({req, " rx strobes"}, n_rx, exp_valid);
    chk({req, " other strobes"}, n_rst + n_need, 0);
    if (exp_valid != 0) chk({req, " rx bit"}, last_rx, int'(b));
  endtask

  task automatic write_bit(input string req, input bit b);
    write_slot(req, b, b ? 1 : (od_m ? 8 : 60), 1);
  endtask

  task automatic read_slot(input string req, input bit b);
    int t_valid, t_rel, t_chk, t_end;
    t_valid = od_m ? 2 : 15;
    t_rel   = od_m ? 3 : 30;
    t_chk   = od_m ? 4 : 45;
    t_end   = od_m ? 14 : 75;
    clr();
    pd_tag = req;
    tx_en = 1'b1;
    tx_bit = b;
    pd_exp = 2;
    mst_rel = 1'b0;
    wait_us(1);
    mst_rel = 1'b1;
    tx_en = 1'b0;
    pd_exp = b ? 0 : 1;
    wait_us(t_valid - 1);
    chk({req, " bus at data-valid"}, int'(bus), int'(b));
    wait_us(t_rel - t_valid);
    pd_exp = 2;
    wait_us(1);
    pd_exp = 0;
    wait_us(t_chk - t_rel - 1);
    chk({req, " bus released"}, int'(bus), 1);
    wait_us(t_end - t_chk);
    chk({req, " need strobes"}, n_need, 1);
    chk({req, " other strobes"}, n_rx + n_rst, 0);
  endtask

  initial begin
    repeat (200000 - 10000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    chk("R1 pull_dn in reset", int'(pull_dn), 0);
    rst = 1'b0;
    pd_exp = 0;
    pd_tag = "R1";
    repeat (20) @(negedge clk);
    chk("R1 regular speed", int'(od_active), 0);
    chk("R1 no strobes", n_rst + n_rx + n_need, 0);

    do_reset("R2 R3 reset 480us", 480, 1, 1'b0, 0);
    do_reset("R2 479us not reset", 479, 0, 1'b0, 0);

    write_bit("R4 write1", 1'b1);
    write_bit("R4 write0", 1'b0);
    write_bit("R4 write1 b", 1'b1);
    write_bit("R4 write1 c", 1'b1);
    write_bit("R4 write0 b", 1'b0);

    read_slot("R5 read0", 1'b0);
    read_slot("R5 read1", 1'b1);

    do_reset("R9 200us ignored", 200, 0, 1'b0, 0);
    write_bit("R9 slot after ignored", 1'b0);
    write_slot("R9 120us still slot", 1'b0, 120, 1);
    write_slot("R9 121us ignored", 1'b0, 121, 0);

    @(negedge clk); od_req = 1'b1;
    @(negedge clk); od_req = 1'b0;
    od_m = 1'b1;
    wait_us(2);
    chk("R6 overdrive set", int'(od_active), 1);
    write_bit("R6 od write1", 1'b1);
    write_bit("R6 od write0", 1'b0);
    read_slot("R6 R5 od read0", 1'b0);
    read_slot("R6 R5 od read1", 1'b1);

    do_reset("R8 od 60us reset", 60, 1, 1'b1, 0);
    do_reset("R8 od 48us reset", 48, 1, 1'b1, 0);
    do_reset("R8 od 80us reset", 80, 1, 1'b1, 0);
    do_reset("R9 od 81us ignored", 81, 0, 1'b1, 0);
    do_reset("R9 od 30us ignored", 30, 0, 1'b1, 0);
    write_bit("R9 od slot after ignored", 1'b1);

    do_reset("R7 od long reset", 500, 1, 1'b0, 0);
    write_bit("R7 regular slot after", 1'b0);

    tx_en = 1'b1;
    tx_bit = 1'b0;
    do_reset("R10 read0 held to reset", 500, 1, 1'b0, 35);
    write_bit("R10 slot after abort", 1'b1);

    pd_exp = 2;
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule